// File: doc/BRIEF.md
# Auto-Precharge Write Sequencer for DDR SDRAM

This block runs one complete write access on a single bank of a double-data-rate SDRAM. A request carries a bank, a row, a column and four data words. The block opens the row, issues a write that closes the row automatically afterwards, and places the burst on the data outputs. It then holds the bus in no-operation until the bank has finished precharging and is idle again. Clock-enable stays high throughout.

The minimum row-to-column delay, minimum row-active time, write recovery and precharge period are all given as whole-clock counts on input ports. These counts are sampled once, when a request is accepted. No explicit precharge command is ever issued. The internal precharge starts at whichever comes later: the end of write recovery after the last data beat, or the end of the minimum row-active time. The bank counts as idle once the precharge count has then elapsed.

Data is modelled at clock granularity. In each data clock, one word belongs to the rising strobe edge and one to the falling edge. A strobe-enable window covers the preamble clock, the two data clocks and the postamble clock.

Top module: `sdr_apw_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, done, dqs_oe and dq_en are low, and cmd is NOP. The cmd encoding is {ras_n, cas_n, we_n}: NOP = 3'b111, ACTIVE = 3'b011, WRITE = 3'b100.
- R2: A request with req_valid high is sampled at a clock edge while busy is low. In the following cycle, cmd is ACTIVE, ba carries the bank and addr carries the full row, including bit 10. busy is high from that cycle on.
- R3: WRITE appears max(t_rcd,1) cycles after ACTIVE and carries the same bank. Column bits 0 to 9 go to addr[9:0], addr[10] is 1 to request auto precharge, and the remaining addr bits are 0 for a 10-bit column.
- R4: Each accepted request yields exactly one ACTIVE and one WRITE. Every other cycle carries NOP.
- R5: dq_en is high for the two cycles that follow the WRITE cycle by one and two clocks. Word k of req_data sits at bits [16k+15:16k]. The first data cycle carries word 0 on dq_rise and word 1 on dq_fall. The second carries word 2 and word 3. dm is 0 at all times.
- R6: dqs_oe is high from the WRITE cycle through three cycles after it: a preamble, two data cycles and a postamble. It is low otherwise.
- R7: Let W be the WRITE cycle and A the ACTIVE cycle. done pulses for one cycle at P + max(t_rp,1), where P = max(W + 2 + max(t_wr,1), A + t_ras). busy is high from A through that cycle and low in the next.
- R8: A request raised while busy is high is dropped. It produces no command and does not shift the timing of the sequence in progress.
- R9: Changes to t_rcd, t_ras, t_wr or t_rp after a request has been accepted do not affect that sequence.
- R10: cke is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request |
| req_bank | input | 2 | Bank of the request |
| req_row | input | 14 | Row of the request |
| req_col | input | 10 | Column of the request |
| req_data | input | 64 | Four data words, word 0 in the low bits |
| t_rcd | input | 8 | Row-to-column delay in clocks |
| t_ras | input | 8 | Minimum row-active time in clocks |
| t_wr | input | 8 | Write recovery in clocks |
| t_rp | input | 8 | Precharge period in clocks |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Bank idle again (one-cycle pulse) |
| cke | output | 1 | Clock enable, held high |
| cmd | output | 3 | {ras_n, cas_n, we_n} |
| ba | output | 2 | Bank address |
| addr | output | 14 | Row or column address |
| dqs_oe | output | 1 | Strobe drive window |
| dq_en | output | 1 | Data beat valid |
| dq_rise | output | 16 | Word for the rising strobe edge |
| dq_fall | output | 16 | Word for the falling strobe edge |
| dm | output | 2 | Data mask |

## Verification
The assertions rely on reset being applied before any request, and on the timing counts fitting their 8-bit ports. They place no limit on when req_valid may rise. The ignore rule therefore has to hold for requests raised in any busy cycle, including while the strobe window is open. The stimulus covers all-zero counts (clamped to one clock), cases where the row-active minimum dominates and cases where write recovery dominates. It also changes the timing counts and raises a stray request partway through a sequence, and starts a new request in the first cycle after busy falls.

// File: rtl/sdr_apw_pkg.sv
package sdr_apw_pkg;

  typedef enum logic [2:0] {
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_NOP = 3'b111
  } cmd_e;

  localparam int BURST_WORDS = 4;
  localparam int BURST_CLK   = BURST_WORDS / 2;
  localparam int DQSS_CLK    = 1;
  localparam int A10_BIT     = 10;

  function automatic int floor1(int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int write_slot(int rcd);
    return floor1(rcd);
  endfunction

  function automatic int last_beat_slot(int rcd);
    return write_slot(rcd) + DQSS_CLK + BURST_CLK - 1;
  endfunction

  function automatic int precharge_slot(int rcd, int ras, int wr);
    int rec;
    rec = last_beat_slot(rcd) + floor1(wr);
    return (rec > ras) ? rec : ras;
  endfunction

  function automatic int ready_slot(int rcd, int ras, int wr, int rp);
    return precharge_slot(rcd, ras, wr) + floor1(rp);
  endfunction

endpackage

// File: rtl/sdr_apw_timer.sv
module sdr_apw_timer
  import sdr_apw_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int OFF_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] t_rcd,
  input  logic [CNT_W-1:0] t_ras,
  input  logic [CNT_W-1:0] t_wr,
  input  logic [CNT_W-1:0] t_rp,
  output logic             busy,
  output logic [OFF_W-1:0] cnt,
  output logic [OFF_W-1:0] w_slot,
  output logic             ev_pre,
  output logic             ev_done
);

  logic [OFF_W-1:0] p_slot;
  logic [OFF_W-1:0] r_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      w_slot <= '0;
      p_slot <= '0;
      r_slot <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= '0;
      w_slot <= OFF_W'(write_slot(int'(t_rcd)));
      p_slot <= OFF_W'(precharge_slot(int'(t_rcd), int'(t_ras), int'(t_wr)));
      r_slot <= OFF_W'(ready_slot(int'(t_rcd), int'(t_ras), int'(t_wr), int'(t_rp)));
    end else if (busy) begin
      if (cnt == r_slot) busy <= 1'b0;
      else               cnt  <= cnt + OFF_W'(1);
    end
  end

  assign ev_pre  = busy && (cnt == p_slot);
  assign ev_done = busy && (cnt == r_slot);

endmodule

// File: rtl/sdr_apw_cmd.sv
module sdr_apw_cmd
  import sdr_apw_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 14,
  parameter int OFF_W  = 10
) (
  input  logic              busy,
  input  logic [OFF_W-1:0]  cnt,
  input  logic [OFF_W-1:0]  w_slot,
  input  logic [BA_W-1:0]   bank_q,
  input  logic [ROW_W-1:0]  row_q,
  input  logic [COL_W-1:0]  col_q,
  output cmd_e              cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ev_act,
  output logic              ev_wr
);

  logic [ADDR_W-1:0] col_map;

  // column bits skip the auto-precharge position
  for (genvar i = 0; i < ADDR_W; i++) begin : g_colmap
    if (i == A10_BIT) begin : g_ap
      assign col_map[i] = 1'b1;
    end else if (i < A10_BIT) begin : g_lo
      if (i < COL_W) begin : g_use
        assign col_map[i] = col_q[i];
      end else begin : g_zero
        assign col_map[i] = 1'b0;
      end
    end else begin : g_hi
      if (i - 1 < COL_W) begin : g_use
        assign col_map[i] = col_q[i-1];
      end else begin : g_zero
        assign col_map[i] = 1'b0;
      end
    end
  end

  assign ev_act = busy && (cnt == '0);
  assign ev_wr  = busy && (cnt == w_slot);

  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    if (ev_act) begin
      cmd  = CMD_ACT;
      ba   = bank_q;
      addr = ADDR_W'(row_q);
    end else if (ev_wr) begin
      cmd  = CMD_WR;
      ba   = bank_q;
      addr = col_map;
    end
  end

endmodule

// File: rtl/sdr_apw_data.sv
module sdr_apw_data
  import sdr_apw_pkg::*;
#(
  parameter int DQ_W  = 16,
  parameter int OFF_W = 10
) (
  input  logic                        busy,
  input  logic [OFF_W-1:0]            cnt,
  input  logic [OFF_W-1:0]            w_slot,
  input  logic [BURST_WORDS*DQ_W-1:0] data_q,
  output logic                        dqs_oe,
  output logic                        dq_en,
  output logic [DQ_W-1:0]             dq_rise,
  output logic [DQ_W-1:0]             dq_fall,
  output logic [DQ_W/8-1:0]           dm,
  output logic [BURST_CLK-1:0]        ev_beat
);

  localparam int WIN_LAST = DQSS_CLK + BURST_CLK;

  for (genvar b = 0; b < BURST_CLK; b++) begin : g_beat
    assign ev_beat[b] = busy && (cnt == w_slot + OFF_W'(DQSS_CLK + b));
  end

  assign dq_en  = |ev_beat;
  assign dqs_oe = busy && (cnt >= w_slot) && (cnt <= w_slot + OFF_W'(WIN_LAST));
  assign dm     = '0;

  always_comb begin
    dq_rise = '0;
    dq_fall = '0;
    for (int b = 0; b < BURST_CLK; b++) begin
      if (ev_beat[b]) begin
        dq_rise = data_q[(2*b)*DQ_W +: DQ_W];
        dq_fall = data_q[(2*b+1)*DQ_W +: DQ_W];
      end
    end
  end

endmodule

// File: rtl/sdr_apw_seq.sv
module sdr_apw_seq
  import sdr_apw_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 14,
  parameter int DQ_W   = 16,
  parameter int CNT_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [BA_W-1:0]             req_bank,
  input  logic [ROW_W-1:0]            req_row,
  input  logic [COL_W-1:0]            req_col,
  input  logic [BURST_WORDS*DQ_W-1:0] req_data,
  input  logic [CNT_W-1:0]            t_rcd,
  input  logic [CNT_W-1:0]            t_ras,
  input  logic [CNT_W-1:0]            t_wr,
  input  logic [CNT_W-1:0]            t_rp,
  output logic                        busy,
  output logic                        done,
  output logic                        cke,
  output logic [2:0]                  cmd,
  output logic [BA_W-1:0]             ba,
  output logic [ADDR_W-1:0]           addr,
  output logic                        dqs_oe,
  output logic                        dq_en,
  output logic [DQ_W-1:0]             dq_rise,
  output logic [DQ_W-1:0]             dq_fall,
  output logic [DQ_W/8-1:0]           dm
);

  localparam int OFF_W = CNT_W + 2;

  logic                        start;
  logic [OFF_W-1:0]            cnt;
  logic [OFF_W-1:0]            w_slot;
  logic [BA_W-1:0]             bank_q;
  logic [ROW_W-1:0]            row_q;
  logic [COL_W-1:0]            col_q;
  logic [BURST_WORDS*DQ_W-1:0] data_q;
  cmd_e                        cmd_w;

  // named internal events for the checker
  logic                 ev_act;
  logic                 ev_wr;
  logic                 ev_pre;
  logic                 ev_done;
  logic [BURST_CLK-1:0] ev_beat;

  assign start = req_valid && !busy;
  assign cke   = 1'b1;
  assign done  = ev_done;
  assign cmd   = cmd_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      data_q <= '0;
    end else if (start) begin
      bank_q <= req_bank;
      row_q  <= req_row;
      col_q  <= req_col;
      data_q <= req_data;
    end
  end

  sdr_apw_timer #(.CNT_W(CNT_W), .OFF_W(OFF_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .t_rcd(t_rcd), .t_ras(t_ras), .t_wr(t_wr), .t_rp(t_rp),
    .busy(busy), .cnt(cnt), .w_slot(w_slot),
    .ev_pre(ev_pre), .ev_done(ev_done)
  );

  sdr_apw_cmd #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W),
                .ADDR_W(ADDR_W), .OFF_W(OFF_W)) cmd_i (
    .busy(busy), .cnt(cnt), .w_slot(w_slot),
    .bank_q(bank_q), .row_q(row_q), .col_q(col_q),
    .cmd(cmd_w), .ba(ba), .addr(addr),
    .ev_act(ev_act), .ev_wr(ev_wr)
  );

  sdr_apw_data #(.DQ_W(DQ_W), .OFF_W(OFF_W)) data_i (
    .busy(busy), .cnt(cnt), .w_slot(w_slot), .data_q(data_q),
    .dqs_oe(dqs_oe), .dq_en(dq_en), .dq_rise(dq_rise), .dq_fall(dq_fall),
    .dm(dm), .ev_beat(ev_beat)
  );

endmodule

// File: rtl/sdr_apw_chk.sv
module sdr_apw_chk #(
  parameter int ADDR_W = 14,
  parameter int DQ_W   = 16,
  parameter int NBEAT  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic              cke,
  input logic [2:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic              dqs_oe,
  input logic              dq_en,
  input logic [DQ_W/8-1:0] dm,
  input logic              ev_wr,
  input logic              ev_pre,
  input logic              ev_done,
  input logic [NBEAT-1:0]  ev_beat
);

  a_r10_cke_high: assert property (@(posedge clk) disable iff (!rst_n) cke);

  a_r2_accept_act: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> (busy && cmd == 3'b011));

  a_r8_no_act_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cmd != 3'b011));

  a_r3_ap_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b100) |-> addr[10]);

  a_r4_cmd_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 3'b111) |-> busy);

  a_r5_beat_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    dq_en |-> dqs_oe);

  a_r5_mask_low: assert property (@(posedge clk) disable iff (!rst_n)
    dm == '0);

  a_r5_beats_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    ev_beat[0] |=> ev_beat[NBEAT-1]);

  a_r6_preamble_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |-> (dqs_oe && !dq_en));

  a_r6_oe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_oe |-> busy);

  a_r7_done_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r7_pre_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pre |-> (!ev_done && !dq_en));

endmodule

bind sdr_apw_seq sdr_apw_chk #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .NBEAT(sdr_apw_pkg::BURST_CLK)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .cke(cke), .cmd(cmd), .addr(addr), .dqs_oe(dqs_oe), .dq_en(dq_en), .dm(dm),
  .ev_wr(ev_wr), .ev_pre(ev_pre), .ev_done(ev_done), .ev_beat(ev_beat)
);

// File: tb/sdr_apw_seq_tb.sv
`timescale 1ns/1ps
module sdr_apw_seq_tb_top;

  localparam int K_ACT = 0, K_WR = 1, K_BAD = 2, K_OEON = 3, K_BEAT = 4,
                 K_OEOFF = 5, K_DONE = 6, K_BUSYF = 7;

  typedef struct {
    int          cyc;
    int          kind;
    logic [63:0] val;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [13:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic [63:0] req_data = '0;
  logic [7:0]  t_rcd = '0, t_ras = '0, t_wr = '0, t_rp = '0;
  logic        busy, done, cke, dqs_oe, dq_en;
  logic [2:0]  cmd;
  logic [1:0]  ba, dm;
  logic [13:0] addr;
  logic [15:0] dq_rise, dq_fall;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    mon_on = 1'b0;
  bit    ended = 1'b0;
  string ctx = "R2";
  ev_t   q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdr_apw_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_data(req_data),
    .t_rcd(t_rcd), .t_ras(t_ras), .t_wr(t_wr), .t_rp(t_rp),
    .busy(busy), .done(done), .cke(cke), .cmd(cmd), .ba(ba), .addr(addr),
    .dqs_oe(dqs_oe), .dq_en(dq_en), .dq_rise(dq_rise), .dq_fall(dq_fall), .dm(dm)
  );

  function automatic int at1(int v);
    if (v < 1) return 1;
    return v;
  endfunction

  function automatic string kreq(int k);
    case (k)
      K_ACT:            return "R2";
      K_WR:             return "R3";
      K_BAD:            return "R4";
      K_BEAT:           return "R5";
      K_OEON, K_OEOFF:  return "R6";
      default:          return "R7";
    endcase
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(int c, int k, logic [63:0] v);
    ev_t e;
    e.cyc = c; e.kind = k; e.val = v;
    q.push_back(e);
  endtask

  // monitor: pops expectations as observed events occur
  task automatic observe(int k, logic [63:0] v);
    ev_t e;
    n_chk++;
    if (q.size() == 0) begin
      n_bad++;
      $display("FAIL %s/%s unexpected kind=%0d actual=%h expected=none (cycle %0d)",
               kreq(k), ctx, k, v, cyc);
    end else begin
      e = q.pop_front();
      if (e.kind != k || e.cyc != cyc || e.val !== v) begin
        n_bad++;
        $display("FAIL %s/%s actual kind=%0d cyc=%0d val=%h expected kind=%0d cyc=%0d val=%h",
                 kreq(e.kind), ctx, k, cyc, v, e.kind, e.cyc, e.val);
      end
    end
  endtask

  logic prev_oe = 1'b0, prev_busy = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      check(cke === 1'b1, "R10", 64'(cke), 64'd1);
      check(dm === 2'b00, "R5", 64'(dm), 64'd0);
      if (cmd === 3'b011)      observe(K_ACT, {48'd0, ba, addr});
      else if (cmd === 3'b100) observe(K_WR, {48'd0, ba, addr});
      else if (cmd !== 3'b111) observe(K_BAD, 64'(cmd));
      if (dqs_oe && !prev_oe)  observe(K_OEON, 64'd0);
      if (dq_en)               observe(K_BEAT, {32'd0, dq_rise, dq_fall});
      if (!dqs_oe && prev_oe)  observe(K_OEOFF, 64'd0);
      if (done)                observe(K_DONE, 64'd0);
      if (!busy && prev_busy)  observe(K_BUSYF, 64'd0);
      prev_oe   = dqs_oe;
      prev_busy = busy;
    end
  end

  // driver: one request, expected events queued; optional stray request while busy
  task automatic do_req(logic [1:0] bk, logic [13:0] row, logic [9:0] col,
                        logic [63:0] d, int rcd, int ras, int wr, int rp, int stray_at);
    int a, w, p, r;
    logic [13:0] wa;
    @(negedge clk);
    t_rcd = 8'(rcd); t_ras = 8'(ras); t_wr = 8'(wr); t_rp = 8'(rp);
    req_bank = bk; req_row = row; req_col = col; req_data = d; req_valid = 1'b1;
    a  = cyc + 1;
    w  = a + at1(rcd);
    wa = '0; wa[9:0] = col; wa[10] = 1'b1;
    p  = w + 2 + at1(wr);
    if (a + ras > p) p = a + ras;
    r  = p + at1(rp);
    push(a, K_ACT, {48'd0, bk, row});
    push(w, K_WR, {48'd0, bk, wa});
    push(w, K_OEON, 64'd0);
    push(w + 1, K_BEAT, {32'd0, d[15:0], d[31:16]});
    push(w + 2, K_BEAT, {32'd0, d[47:32], d[63:48]});
    push(w + 4, K_OEOFF, 64'd0);
    push(r, K_DONE, 64'd0);
    push(r + 1, K_BUSYF, 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
    req_bank = ~bk; req_row = ~row; req_col = ~col; req_data = ~d;
    if (stray_at >= 0) begin
      repeat (stray_at) @(negedge clk);
      // R8: stray request while busy; R9: timing inputs changed mid-sequence
      req_valid = 1'b1;
      t_rcd = 8'd1; t_ras = 8'd90; t_wr = 8'd40; t_rp = 8'd30;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (cyc < r + 1) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy === 1'b0,    "R1", 64'(busy), 64'd0);
    check(done === 1'b0,    "R1", 64'(done), 64'd0);
    check(cmd === 3'b111,   "R1", 64'(cmd), 64'h7);
    check(dqs_oe === 1'b0,  "R1", 64'(dqs_oe), 64'd0);
    check(dq_en === 1'b0,   "R1", 64'(dq_en), 64'd0);
    check(cke === 1'b1,     "R10", 64'(cke), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && cmd === 3'b111, "R1", {61'd0, busy, cmd[1:0]}, 64'h3);
    mon_on = 1'b1;
    prev_busy = busy; prev_oe = dqs_oe;

    ctx = "R7";
    do_req(2'd1, 14'h0123, 10'h055, 64'h4444_3333_2222_1111, 3, 6, 2, 3, -1);
    do_req(2'd2, 14'h0400, 10'h3FF, 64'hDDDD_CCCC_BBBB_AAAA, 2, 20, 1, 2, -1);
    ctx = "R3";
    do_req(2'd3, 14'h3FFF, 10'h000, 64'h0F0F_F0F0_5A5A_A5A5, 0, 0, 0, 0, -1);
    ctx = "R8";
    do_req(2'd0, 14'h1A2B, 10'h2C3, 64'h8765_4321_FEDC_BA98, 4, 5, 3, 2, 2);
    ctx = "R9";
    do_req(2'd1, 14'h2222, 10'h111, 64'h0001_0002_0003_0004, 1, 12, 5, 4, 5);
    ctx = "R4";
    do_req(2'd2, 14'h0F0F, 10'h2AA, 64'hFFFF_0000_FFFF_0000, 5, 9, 1, 1, -1);
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R4", 64'(q.size()), 64'd0);
    check(busy === 1'b0, "R7", 64'(busy), 64'd0);
    finish_run();
  end

endmodule